// File: doc/BRIEF.md
# Scratchpad Read-Back Frame Checker

This block checks the reply that a single-wire bus master collects from a slave after it issues a scratchpad read command. The master's byte-level receiver hands the block one byte at a time. A start pulse opens a frame and carries the command byte that the master sent. The block then expects thirteen payload bytes in a fixed order. It places each one in an output register. While the bytes arrive, a bit-serial CRC-16 engine folds the command byte and the first eleven payload bytes into a running checksum, one byte every eight clock cycles.

When the second checksum byte arrives, the block complements the computed CRC and compares it with the two received bytes. One cycle later it pulses either a pass or a fail output. A done flag is also raised and stays set. After a verdict the block locks. It ignores further start pulses and bytes until the master reports a new bus reset. Bit-level bus timing and any display formatting are handled elsewhere.

Top module: `scratch_frame_chk`

## Requirements
- R1: While reset is asserted, and until the first start after it, pass_o, fail_o, done_o and busy_o are 0 and every capture output (addr_o, status_o, data_o, crc_rx_o) reads 0.
- R2: An accepted start clears every capture output and done_o, and loads cmd_i into the CRC engine from a zero seed. busy_o is high for exactly 8 cycles after each accepted start and after each accepted byte that the CRC covers.
- R3: Payload byte positions are as follows. Bytes 0 and 1 form addr_o[7:0] and addr_o[15:8]. Byte 2 is status_o. Bytes 3 to 10 fill data_o, with byte 3 in data_o[7:0] and byte 10 in data_o[63:56]. Byte 11 is crc_rx_o[7:0] and byte 12 is crc_rx_o[15:8].
- R4: The CRC uses x^16+x^15+x^2+1 in bit-reversed form (0xA001). It starts from 0, takes each byte LSB first, and covers the command byte followed by payload bytes 0 to 10. crc_calc_o is the bitwise complement of the register, so a zero command with eleven zero bytes gives 0xFFFF.
- R5: In the cycle after payload byte 12 is accepted, exactly one of pass_o and fail_o is high, for one cycle only. pass_o requires crc_rx_o[7:0] to match crc_calc_o[7:0] and crc_rx_o[15:8] to match crc_calc_o[15:8]. Otherwise fail_o is high.
- R6: done_o rises together with the pass or fail pulse. It stays high until the next accepted start.
- R7: byte_vld_i is ignored while busy_o is high, and also when no frame is open (after reset or after a bus reset, before any start).
- R8: A start that arrives while a frame is open abandons that frame. Capture begins again from payload byte 0, with the new command byte.
- R9: After a verdict, start_i and byte_vld_i have no effect: captures, done_o and busy_o hold. This lasts until bus_rst_i is pulsed, after which a start is accepted again.
- R10: Priority is bus_rst_i over start_i over byte_vld_i. A byte that comes with a start is dropped. A start that comes with a bus reset is dropped, and the bus reset does not change done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Pulse: master has issued a new bus reset |
| start_i | input | 1 | Pulse: opens a frame |
| cmd_i | input | 8 | Command byte, taken with start_i |
| byte_vld_i | input | 1 | Payload byte strobe |
| byte_i | input | 8 | Payload byte |
| busy_o | output | 1 | CRC engine is shifting; bytes are dropped |
| addr_o | output | 16 | Captured target address |
| status_o | output | 8 | Captured ending/status byte |
| data_o | output | 64 | Captured data bytes, first byte lowest |
| crc_rx_o | output | 16 | Received CRC |
| crc_calc_o | output | 16 | Complemented computed CRC |
| pass_o | output | 1 | One-cycle pulse: CRC matched |
| fail_o | output | 1 | One-cycle pulse: CRC mismatched |
| done_o | output | 1 | Sticky verdict flag |

## Verification
A start and a byte strobe can arrive in the same cycle. So can a bus reset and a start. The bench drives both pairs on a single negative edge. For start with byte, it judges the result by the capture registers reading zero straight afterwards and by a clean pass on the frame that follows. For bus reset with start, it judges by done_o staying high and busy_o staying low, which shows the start was dropped.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  // x^16+x^15+x^2+1, bit-reversed for LSB-first shifting
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'hA001;

  typedef enum logic [1:0] {
    SFC_IDLE = 2'd0,
    SFC_CAPT = 2'd1,
    SFC_LOCK = 2'd2
  } sfc_state_e;

  function automatic logic [CRC_W-1:0] crc_bit_step(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[0] ^ din;
    return (cur >> 1) ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/sfc_crc_engine.sv
module sfc_crc_engine
  import sfc_pkg::*;
#(
  parameter int               DW   = BYTE_W,
  parameter int               CW   = CRC_W,
  parameter logic [CW-1:0]    POLY = CRC_POLY_REV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic [DW-1:0] din_i,
  output logic          busy_o,
  output logic [CW-1:0] crc_o
);

  localparam int CNT_W = $clog2(DW + 1);

  logic [CW-1:0]    crc_q, crc_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign busy_o = (cnt_q != '0);
  assign en     = ld_i | busy_o;

  always_comb begin
    crc_d = crc_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (ld_i) begin
      sh_d  = din_i;
      cnt_d = CNT_W'(DW);
      if (clr_i) crc_d = '0;
    end else if (busy_o) begin
      crc_d = crc_bit_step(crc_q, sh_q[0], POLY);
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      crc_q <= crc_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/sfc_field_capture.sv
module sfc_field_capture
  import sfc_pkg::*;
#(
  parameter int DW         = BYTE_W,
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [DW-1:0]            din_i,
  output logic                     feed_o,
  output logic                     last_o,
  output logic [ADDR_BYTES*DW-1:0] addr_o,
  output logic [DW-1:0]            stat_o,
  output logic [DATA_BYTES*DW-1:0] data_o,
  output logic [2*DW-1:0]          crcrx_o
);

  localparam int STAT_IDX = ADDR_BYTES;
  localparam int DATA_IDX = STAT_IDX + 1;
  localparam int CRCL_IDX = DATA_IDX + DATA_BYTES;
  localparam int TOTAL    = CRCL_IDX + 2;
  localparam int IDX_W    = $clog2(TOTAL);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    slot_q [TOTAL];

  assign feed_o = (idx_q < IDX_W'(CRCL_IDX));
  assign last_o = (idx_q == IDX_W'(TOTAL - 1));

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (wr_i)  idx_d = last_o ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clr_i || wr_i)  idx_q <= idx_d;
  end

  for (genvar k = 0; k < TOTAL; k++) begin : g_slot
    logic          s_en;
    logic [DW-1:0] s_d;
    assign s_en = clr_i | (wr_i & (idx_q == IDX_W'(k)));
    assign s_d  = clr_i ? '0 : din_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[k] <= '0;
      else if (s_en)  slot_q[k] <= s_d;
    end
  end

  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
    assign addr_o[a*DW +: DW] = slot_q[a];
  end

  for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
    assign data_o[d*DW +: DW] = slot_q[DATA_IDX + d];
  end

  assign stat_o  = slot_q[STAT_IDX];
  assign crcrx_o = {slot_q[CRCL_IDX + 1], slot_q[CRCL_IDX]};

endmodule

// File: rtl/sfc_seq_ctrl.sv
module sfc_seq_ctrl
  import sfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_i,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic busy_i,
  input  logic last_i,
  input  logic crc_match_i,
  output logic start_acc_o,
  output logic byte_acc_o,
  output logic pass_o,
  output logic fail_o,
  output logic done_o
);

  sfc_state_e st_q, st_d;
  logic       pass_q, pass_d;
  logic       fail_q, fail_d;
  logic       done_q, done_d;
  logic       fin;

  assign start_acc_o = start_i & ~bus_rst_i & (st_q != SFC_LOCK);
  assign byte_acc_o  = byte_vld_i & ~start_i & ~bus_rst_i & ~busy_i &
                       (st_q == SFC_CAPT);
  assign fin         = byte_acc_o & last_i;

  always_comb begin
    st_d = st_q;
    if (bus_rst_i)        st_d = SFC_IDLE;
    else if (start_acc_o) st_d = SFC_CAPT;
    else if (fin)         st_d = SFC_LOCK;
  end

  always_comb begin
    pass_d = fin &  crc_match_i;
    fail_d = fin & ~crc_match_i;
    done_d = done_q;
    if (start_acc_o) done_d = 1'b0;
    else if (fin)    done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SFC_IDLE;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
      done_q <= done_d;
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign done_o = done_q;

endmodule

// File: rtl/scratch_frame_chk.sv
module scratch_frame_chk
  import sfc_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 8,
  localparam int AW = ADDR_BYTES * BYTE_W,
  localparam int DW = DATA_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic [AW-1:0]     addr_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [DW-1:0]     data_o,
  output logic [CRC_W-1:0]  crc_rx_o,
  output logic [CRC_W-1:0]  crc_calc_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              done_o
);

  logic [1:0]        rsync_q;
  logic              rst_sync_n;
  logic              start_acc, byte_acc;
  logic              feed, last;
  logic              eng_ld;
  logic [BYTE_W-1:0] eng_din;
  logic [CRC_W-1:0]  crc_raw;
  logic              crc_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign eng_ld  = start_acc | (byte_acc & feed);
  assign eng_din = start_acc ? cmd_i : byte_i;

  assign crc_calc_o = ~crc_raw;
  assign crc_match  = (byte_i == crc_calc_o[CRC_W-1 -: BYTE_W]) &&
                      (crc_rx_o[BYTE_W-1:0] == crc_calc_o[BYTE_W-1:0]);

  sfc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_rst_i   (bus_rst_i),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .busy_i      (busy_o),
    .last_i      (last),
    .crc_match_i (crc_match),
    .start_acc_o (start_acc),
    .byte_acc_o  (byte_acc),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .done_o      (done_o)
  );

  sfc_field_capture #(
    .DW         (BYTE_W),
    .ADDR_BYTES (ADDR_BYTES),
    .DATA_BYTES (DATA_BYTES)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (start_acc),
    .wr_i    (byte_acc),
    .din_i   (byte_i),
    .feed_o  (feed),
    .last_o  (last),
    .addr_o  (addr_o),
    .stat_o  (status_o),
    .data_o  (data_o),
    .crcrx_o (crc_rx_o)
  );

  sfc_crc_engine #(
    .DW   (BYTE_W),
    .CW   (CRC_W),
    .POLY (CRC_POLY_REV)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (start_acc),
    .ld_i   (eng_ld),
    .din_i  (eng_din),
    .busy_o (busy_o),
    .crc_o  (crc_raw)
  );

endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] data_o,
  input logic [CW-1:0] crc_rx_o,
  input logic [CW-1:0] crc_calc_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          done_o
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (start_i) run_q <= '0;
    else if (busy_o)  run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(BW));

  // R5
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  // R5
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> !(pass_o || fail_o));

  // R5
  pass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (crc_rx_o == crc_calc_o));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (pass_o || fail_o));

  // R9
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> ($stable(addr_o) && $stable(data_o) && !busy_o && done_o));

endmodule

bind scratch_frame_chk sfc_chk #(
  .AW (AW),
  .DW (DW),
  .CW (sfc_pkg::CRC_W),
  .BW (sfc_pkg::BYTE_W)
) u_sfc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .addr_o     (addr_o),
  .data_o     (data_o),
  .crc_rx_o   (crc_rx_o),
  .crc_calc_o (crc_calc_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .done_o     (done_o)
);

// File: tb/tb_scratch_frame_chk.sv
module tb_scratch_frame_chk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_rst_i, start_i, byte_vld_i;
  logic [7:0]  cmd_i, byte_i;
  logic        busy_o, pass_o, fail_o, done_o;
  logic [15:0] addr_o, crc_rx_o, crc_calc_o;
  logic [7:0]  status_o;
  logic [63:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] fr [13];

  always #2 clk = ~clk;

  scratch_frame_chk dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .start_i(start_i),
    .cmd_i(cmd_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .busy_o(busy_o), .addr_o(addr_o), .status_o(status_o), .data_o(data_o),
    .crc_rx_o(crc_rx_o), .crc_calc_o(crc_calc_o),
    .pass_o(pass_o), .fail_o(fail_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // CRC from the stated polynomial, reflected, zero seed, LSB first
  function automatic logic [15:0] ref_crc(input logic [7:0] cmd);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      b = (i == 0) ? cmd : fr[i-1];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[j]) c = (c >> 1) ^ 16'hA001;
        else             c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic fill_frame(input logic [7:0] cmd, input int seed);
    logic [15:0] c;
    for (int k = 0; k < 11; k++) fr[k] = 8'(seed * 29 + k * 53 + 7);
    c = ref_crc(cmd);
    fr[11] = c[7:0];
    fr[12] = c[15:8];
  endtask

  task automatic pulse_start(input logic [7:0] cmd);
    start_i = 1'b1; cmd_i = cmd;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (busy_o) @(negedge clk);
    byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic bus_reset();
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
  endtask

  task automatic check_fields(input string req);
    logic [63:0] ed;
    for (int k = 0; k < 8; k++) ed[k*8 +: 8] = fr[3+k];
    chk({req, " addr"},   addr_o,   {fr[1], fr[0]});
    chk({req, " status"}, status_o, fr[2]);
    chk({req, " data"},   data_o,   ed);
    chk({req, " crc_rx"}, crc_rx_o, {fr[12], fr[11]});
  endtask

  task automatic t_reset();
    chk("R1 pass", pass_o, 0);
    chk("R1 fail", fail_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 crc_rx", crc_rx_o, 0);
  endtask

  task automatic t_good_frame(input logic [7:0] cmd, input int seed);
    int nb;
    fill_frame(cmd, seed);
    pulse_start(cmd);
    nb = 0;
    while (busy_o) begin nb++; @(negedge clk); end
    chk("R2 busy length after start", nb, 8);
    for (int k = 0; k < 13; k++) send_byte(fr[k]);
    check_fields("R3");
    chk("R4 crc_calc", crc_calc_o, {fr[12], fr[11]});
    chk("R5 pass", pass_o, 1);
    chk("R5 fail", fail_o, 0);
    chk("R6 done", done_o, 1);
    @(negedge clk);
    chk("R5 pass single", pass_o, 0);
    chk("R6 done held", done_o, 1);
    bus_reset();
  endtask

  task automatic t_zero_frame();
    for (int k = 0; k < 11; k++) fr[k] = 8'h00;
    fr[11] = 8'hFF; fr[12] = 8'hFF;
    pulse_start(8'h00);
    for (int k = 0; k < 13; k++) send_byte(fr[k]);
    chk("R4 zero crc", crc_calc_o, 16'hFFFF);
    chk("R4 zero pass", pass_o, 1);
    bus_reset();
  endtask

  task automatic t_bad(input logic hi);
    fill_frame(8'hAA, hi ? 5 : 6);
    if (hi) fr[12] = fr[12] ^ 8'h01;
    else    fr[11] = fr[11] ^ 8'h80;
    pulse_start(8'hAA);
    for (int k = 0; k < 13; k++) send_byte(fr[k]);
    chk(hi ? "R5 fail hi" : "R5 fail lo", fail_o, 1);
    chk("R5 no pass on mismatch", pass_o, 0);
    chk("R6 done on fail", done_o, 1);
    @(negedge clk);
    chk("R5 fail single", fail_o, 0);
  endtask

  task automatic t_lock();
    // block locked from the preceding failed frame
    logic [63:0] d0;
    d0 = data_o;
    pulse_start(8'h33);
    chk("R9 start ignored done", done_o, 1);
    chk("R9 start ignored busy", busy_o, 0);
    chk("R9 data held", data_o, d0);
    send_byte(8'h5A);
    chk("R9 byte ignored busy", busy_o, 0);
    chk("R9 data held after byte", data_o, d0);
    bus_reset();
    pulse_start(8'h33);
    chk("R9 start after bus reset", busy_o, 1);
    chk("R6 done cleared by start", done_o, 0);
    bus_reset();
    while (busy_o) @(negedge clk);
  endtask

  task automatic t_ignore();
    // idle: no frame open
    send_byte(8'h77);
    chk("R7 idle byte ignored", busy_o, 0);
    chk("R7 idle addr", addr_o, 0);
    fill_frame(8'h0F, 9);
    pulse_start(8'h0F);
    send_byte(fr[0]);
    byte_vld_i = 1'b1; byte_i = 8'hEE;
    @(negedge clk);
    byte_vld_i = 1'b0;
    for (int k = 1; k < 13; k++) send_byte(fr[k]);
    check_fields("R7");
    chk("R7 pass despite busy byte", pass_o, 1);
    bus_reset();
  endtask

  task automatic t_abort();
    fill_frame(8'h11, 3);
    pulse_start(8'h11);
    for (int k = 0; k < 5; k++) send_byte(fr[k]);
    fill_frame(8'h22, 4);
    pulse_start(8'h22);
    chk("R8 restart clears addr", addr_o, 0);
    chk("R8 restart clears data", data_o, 0);
    for (int k = 0; k < 13; k++) send_byte(fr[k]);
    check_fields("R8");
    chk("R8 pass after restart", pass_o, 1);
    bus_reset();
  endtask

  task automatic t_priority();
    fill_frame(8'h5C, 12);
    start_i = 1'b1; cmd_i = 8'h5C; byte_vld_i = 1'b1; byte_i = 8'h99;
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
    chk("R10 byte with start dropped", addr_o, 0);
    for (int k = 0; k < 13; k++) send_byte(fr[k]);
    chk("R10 pass after start+byte", pass_o, 1);
    @(negedge clk);
    bus_rst_i = 1'b1; start_i = 1'b1; cmd_i = 8'h01;
    @(negedge clk);
    bus_rst_i = 1'b0; start_i = 1'b0;
    chk("R10 start with bus reset dropped busy", busy_o, 0);
    chk("R10 bus reset keeps done", done_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_rst_i = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0;
    cmd_i = 8'h00; byte_i = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good_frame(8'hBE, 1);
    t_good_frame(8'h3C, 2);
    t_zero_frame();
    t_bad(1'b1);
    bus_reset();
    t_bad(1'b0);
    t_lock();
    t_ignore();
    t_abort();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule